// File: doc/BRIEF.md
# Bit-Serial Column Readout Accumulator

This block turns a series of per-column row counts from a binary-cell compute-in-memory bank into one unsigned dot product. Each weight is held as 8 adjacent one-bit cells in a row, so column j of a weight group carries weight bit j. The activation vector is driven onto the rows one bit at a time, least significant first. For each pair of activation bit k and column j, the analog side delivers a thermometer code whose height is the number of rows where both the activation bit and the stored bit are 1. The block decodes that code into a binary count, shifts it left by j and by k, and adds it to an accumulator. After the last pair it presents the finished sum with a one-cycle completion pulse.

A build-time parameter picks one of two readout schedules. With a shared converter, a single code arrives per cycle and the block walks all 8 columns for each activation bit, which takes 64 cycles. With a converter per column, all 8 codes arrive together and the block needs one cycle per activation bit, which takes 8 cycles. The block drives the current activation bit index and column index, so the array side knows what to present. A start pulse begins a computation and clears the accumulator.

Top module: `bsr_readout`

## Requirements
- R1: A thermometer input decodes to a count equal to the position of its highest set bit plus one, or 0 when no bit is set. Clear bits below the highest set bit do not change the count. Each code is ROWS (128) bits wide, so the count ranges over 0..128.
- R2: The result equals the sum, over every (activation bit k, column j) step, of the decoded count shifted left by j+k. This is the unsigned sum over all rows of activation times weight.
- R3: In shared mode (SHARED=1), step s of a run presents column s mod 8 on col_sel and activation bit s div 8 on act_bit. A run is 64 steps long, starting from activation bit 0 and column 0.
- R4: In dedicated mode (SHARED=0), therm_in carries column j's code in bits [j*ROWS +: ROWS]. All columns are decoded in the same cycle, col_sel stays 0, and act_bit counts 0..7 over an 8-step run.
- R5: When start is sampled high while the block is idle, busy rises on that edge. done is high for exactly one cycle, after the edge that comes STEPS edges later (64 in shared mode, 8 in dedicated mode). busy falls on the same edge that raises done.
- R6: A start pulse while busy has no effect: the run keeps its step order, its completion time and its result.
- R7: result changes only on the edge that raises done, and holds its value during the whole of the next run.
- R8: After reset, busy, done, result, act_bit and col_sel are all 0.
- R9: The full-scale case (all 128 rows with weight 255 and activation 255) gives 8323200 without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation; ignored while busy |
| therm_in | input | (SHARED?1:WBITS)*ROWS | Thermometer code(s) for the step shown on act_bit/col_sel |
| act_bit | output | clog2(ABITS) | Activation bit currently driven onto the rows |
| col_sel | output | clog2(WBITS) | Column whose code is expected (shared mode) |
| busy | output | 1 | A computation is in progress |
| done | output | 1 | One-cycle pulse: result is new |
| result | output | clog2(ROWS+1)+WBITS+ABITS | Accumulated dot product |

## Verification
The hardest case to reach from the ports is a thermometer code that matches the real row contents for every one of the 64 (bit, column) steps. The code must change in the very cycle the block moves its indices, and no single fixed pattern exercises the double shift. The bench therefore keeps a model array of 128 weights and activations. On every falling edge it reads act_bit and col_sel and recomputes the AND-count to build each code. This lets uniform fills, pseudo-random fills, the full-scale corner and codes with an injected gap be run through both schedules. Stray start pulses in the middle of a run and a result read taken mid-run cover the ignore and hold rules.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } bsr_phase_e;

endpackage

// File: rtl/bsr_therm2bin.sv
// Thermometer to binary: count = index of highest set bit + 1.
module bsr_therm2bin #(
    parameter int ROWS  = 128,
    parameter int CNT_W = 8
) (
    input  logic [ROWS-1:0]  therm,
    output logic [CNT_W-1:0] count
);

    always_comb begin
        count = '0;
        for (int i = 0; i < ROWS; i++) begin
            if (therm[i]) begin
                count = CNT_W'(i + 1);
            end
        end
    end

endmodule

// File: rtl/bsr_col_weight.sv
// Column significance weighting: sum of count_j << (base + j).
module bsr_col_weight #(
    parameter int CNT_W = 8,
    parameter int NCONV = 1,
    parameter int COL_W = 3,
    parameter int SUM_W = 16
) (
    input  logic [NCONV*CNT_W-1:0] counts,
    input  logic [COL_W-1:0]       col_base,
    output logic [SUM_W-1:0]       sum
);

    always_comb begin
        sum = '0;
        for (int j = 0; j < NCONV; j++) begin
            sum = sum + (SUM_W'(counts[j*CNT_W +: CNT_W]) << (int'(col_base) + j));
        end
    end

endmodule

// File: rtl/bsr_seq.sv
// Step sequencer: walks (activation bit, column) pairs, emits done.
module bsr_seq
    import bsr_pkg::*;
#(
    parameter int  STEPS  = 64,
    parameter int  COL_W  = 3,
    parameter int  ABIT_W = 3,
    parameter bit  SHARED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              clear,
    output logic              last,
    output logic              done,
    output logic [ABIT_W-1:0] act_bit,
    output logic [COL_W-1:0]  col_sel
);

    localparam int STEP_W = $clog2(STEPS);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    typedef struct packed {
        bsr_phase_e        ph;
        logic [STEP_W-1:0] step;
        logic              done;
    } seq_t;

    seq_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ph   = PH_RUN;
                    st_d.step = '0;
                end
            end
            PH_RUN: begin
                if (st_q.step == LAST_STEP) begin
                    st_d.ph   = PH_IDLE;
                    st_d.step = '0;
                    st_d.done = 1'b1;
                end else begin
                    st_d.step = st_q.step + 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, step: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy  = (st_q.ph == PH_RUN);
    assign clear = !busy && start;
    assign last  = busy && (st_q.step == LAST_STEP);
    assign done  = st_q.done;

    generate
        if (SHARED) begin : g_shared
            assign col_sel = st_q.step[COL_W-1:0];
            assign act_bit = st_q.step[COL_W +: ABIT_W];
        end else begin : g_dedicated
            assign col_sel = '0;
            assign act_bit = st_q.step[ABIT_W-1:0];
        end
    endgenerate

    // R5: completion lasts one cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: completion only follows the final step of a run
    a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy) && ($past(st_q.step) == LAST_STEP));

    // R6: a start while running does not disturb stepping
    a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && (st_q.step != LAST_STEP)) |=>
            busy && (st_q.step == $past(st_q.step) + STEP_W'(1)));

    // R3: steps advance by one inside a run
    a_r3_step_order: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (st_q.step == $past(st_q.step) + STEP_W'(1)));

endmodule

// File: rtl/bsr_readout.sv
// Bit-serial shift-and-add readout for one weight group.
module bsr_readout #(
    parameter int ROWS   = 128,
    parameter int WBITS  = 8,
    parameter int ABITS  = 8,
    parameter bit SHARED = 1'b1
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         start,
    input  logic [(SHARED ? 1 : WBITS)*ROWS-1:0]         therm_in,
    output logic [$clog2(ABITS)-1:0]                     act_bit,
    output logic [$clog2(WBITS)-1:0]                     col_sel,
    output logic                                         busy,
    output logic                                         done,
    output logic [$clog2(ROWS+1)+WBITS+ABITS-1:0]        result
);

    localparam int NCONV  = SHARED ? 1 : WBITS;
    localparam int CNT_W  = $clog2(ROWS + 1);
    localparam int COL_W  = $clog2(WBITS);
    localparam int ABIT_W = $clog2(ABITS);
    localparam int STEPS  = SHARED ? WBITS * ABITS : ABITS;
    localparam int SUM_W  = CNT_W + WBITS;
    localparam int ACC_W  = CNT_W + WBITS + ABITS;

    logic                   clear, last;
    logic [NCONV*CNT_W-1:0] cnt_vec;
    logic [COL_W-1:0]       col_base;
    logic [SUM_W-1:0]       col_sum;
    logic [ACC_W-1:0]       term;

    bsr_seq #(
        .STEPS  (STEPS),
        .COL_W  (COL_W),
        .ABIT_W (ABIT_W),
        .SHARED (SHARED)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .busy    (busy),
        .clear   (clear),
        .last    (last),
        .done    (done),
        .act_bit (act_bit),
        .col_sel (col_sel)
    );

    generate
        for (genvar g = 0; g < NCONV; g++) begin : g_conv
            bsr_therm2bin #(
                .ROWS  (ROWS),
                .CNT_W (CNT_W)
            ) u_t2b (
                .therm (therm_in[g*ROWS +: ROWS]),
                .count (cnt_vec[g*CNT_W +: CNT_W])
            );
        end
        if (SHARED) begin : g_base_sh
            assign col_base = col_sel;
        end else begin : g_base_ded
            assign col_base = '0;
        end
    endgenerate

    bsr_col_weight #(
        .CNT_W (CNT_W),
        .NCONV (NCONV),
        .COL_W (COL_W),
        .SUM_W (SUM_W)
    ) u_wgt (
        .counts   (cnt_vec),
        .col_base (col_base),
        .sum      (col_sum)
    );

    assign term = ACC_W'(col_sum) << act_bit;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] res;
    } dp_t;

    dp_t dp_q, dp_d;

    always_comb begin
        dp_d = dp_q;
        if (clear) begin
            dp_d.acc = '0;
        end else if (busy) begin
            dp_d.acc = dp_q.acc + term;
        end
        if (last) begin
            dp_d.res = dp_q.acc + term;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign result = dp_q.res;

    // R9: the sum never wraps inside a run
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (dp_q.acc >= $past(dp_q.acc)));

    // R7: result moves only at completion
    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

endmodule

// File: tb/sim_bsr_readout.sv
`timescale 1ns/1ps
module sim_bsr_readout;

    localparam int ROWS = 128;
    localparam int NV   = 8;

    // uniform-fill vector table: weight, activation, expected sum
    localparam logic [7:0] TW[NV] = '{8'd0, 8'd255, 8'd1, 8'd128, 8'd1, 8'hAA, 8'h0F, 8'd3};
    localparam logic [7:0] TX[NV] = '{8'd0, 8'd255, 8'd1, 8'd1, 8'd128, 8'h55, 8'hF0, 8'd5};
    localparam int         TE[NV] = '{0, 8323200, 128, 16384, 16384, 1849600, 460800, 1920};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start0 = 1'b0, start1 = 1'b0;
    logic [ROWS-1:0]   therm0 = '0;
    logic [8*ROWS-1:0] therm1 = '0;
    logic [2:0]  act0, col0, act1, col1;
    logic        busy0, done0, busy1, done1;
    logic [23:0] result0, result1;

    logic [7:0] w_mem[ROWS];
    logic [7:0] x_mem[ROWS];
    logic bubble = 1'b0;

    int nchk = 0, nfail = 0;
    longint cyc = 0, t0 = 0;
    int d0_n, d1_n, err0, err1, idx0 = 0, idx1 = 0;
    longint d0_c, d1_c, d0_r, d1_r;

    always #10 clk = ~clk;

    bsr_readout #(.SHARED(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start0), .therm_in(therm0),
        .act_bit(act0), .col_sel(col0), .busy(busy0), .done(done0), .result(result0));

    bsr_readout #(.SHARED(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start1), .therm_in(therm1),
        .act_bit(act1), .col_sel(col1), .busy(busy1), .done(done1), .result(result1));

    function automatic int and_count(int k, int j);
        int c = 0;
        for (int r = 0; r < ROWS; r++) c += int'(x_mem[r][k] & w_mem[r][j]);
        return c;
    endfunction

    function automatic logic [ROWS-1:0] thermo(int n, logic bub);
        logic [ROWS-1:0] t;
        t = (n == 0) ? '0 : ((ROWS'(1) << n) - ROWS'(1));
        if (bub && n >= 2) t[0] = 1'b0;
        return t;
    endfunction

    // array model: present codes for the indices the DUTs show
    always @(negedge clk) begin
        therm0 <= thermo(and_count(int'(act0), int'(col0)), bubble);
        for (int j = 0; j < 8; j++)
            therm1[j*ROWS +: ROWS] <= thermo(and_count(int'(act1), j), bubble);
    end

    // completion and step-order monitor
    always @(negedge clk) begin
        if (done0) begin d0_n++; d0_c = cyc; d0_r = longint'(result0); end
        if (done1) begin d1_n++; d1_c = cyc; d1_r = longint'(result1); end
        if (busy0) begin
            if (int'(act0) * 8 + int'(col0) != idx0) err0++;
            idx0++;
        end else idx0 = 0;
        if (busy1) begin
            if (int'(act1) != idx1 || col1 != 3'd0) err1++;
            idx1++;
        end else idx1 = 0;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            nfail++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected < 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic fill_uni(input logic [7:0] w, input logic [7:0] x);
        for (int r = 0; r < ROWS; r++) begin w_mem[r] = w; x_mem[r] = x; end
    endtask

    function automatic longint model_sum();
        longint e = 0;
        for (int r = 0; r < ROWS; r++) e += longint'(x_mem[r]) * longint'(w_mem[r]);
        return e;
    endfunction

    task automatic fill_rand(input logic [31:0] seed);
        logic [31:0] s = seed;
        for (int r = 0; r < ROWS; r++) begin
            s = s * 32'd1664525 + 32'd1013904223;
            w_mem[r] = s[23:16];
            x_mem[r] = s[31:24];
        end
    endtask

    task automatic pulse_both();
        d0_n = 0; d1_n = 0; err0 = 0; err1 = 0;
        @(negedge clk); start0 = 1'b1; start1 = 1'b1;
        @(negedge clk); start0 = 1'b0; start1 = 1'b0;
        t0 = cyc;
    endtask

    task automatic check_runs(input longint expv, input string vreq);
        chk(d0_n == 1 && d0_c == t0 + 64, "R5 shared latency", d0_c - t0, 64);
        chk(d0_r == expv, vreq, d0_r, expv);
        chk(d1_n == 1 && d1_c == t0 + 8, "R4 dedicated latency", d1_c - t0, 8);
        chk(d1_r == expv, "R4 dedicated value", d1_r, expv);
        chk(err0 == 0, "R3 shared step order", err0, 0);
        chk(err1 == 0, "R4 dedicated step order", err1, 0);
    endtask

    task automatic run_vec(input longint expv, input string vreq);
        pulse_both();
        repeat (70) @(negedge clk);
        check_runs(expv, vreq);
    endtask

    initial begin
        longint ea, eb;
        fill_uni(8'd0, 8'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk(!busy0 && !done0 && !busy1 && !done1, "R8 flags", {busy0, done0, busy1, done1}, 0);
        chk(result0 == 0 && result1 == 0, "R8 result", result0 + result1, 0);
        chk(act0 == 0 && col0 == 0 && act1 == 0 && col1 == 0, "R8 indices",
            {act0, col0, act1, col1}, 0);

        // table walk: R2 weighting, R1 decode, R9 full scale at entry 1
        for (int v = 0; v < NV; v++) begin
            fill_uni(TW[v], TX[v]);
            chk(model_sum() == TE[v], "R2 table entry", model_sum(), TE[v]);
            run_vec(TE[v], (v == 1) ? "R9 full scale" : "R2 R1 shared value");
        end

        // pseudo-random rows
        for (int v = 0; v < 4; v++) begin
            fill_rand(32'h1234 + v * 32'h9E37);
            run_vec(model_sum(), "R2 random shared value");
        end

        // R1: gaps below the top of a code are ignored
        fill_rand(32'hC0FFEE);
        bubble = 1'b1;
        run_vec(model_sum(), "R1 bubble code");
        bubble = 1'b0;

        // R6: extra starts during a shared run
        fill_rand(32'hBEEF);
        ea = model_sum();
        pulse_both();
        repeat (20) @(negedge clk);
        start0 = 1'b1; @(negedge clk); start0 = 1'b0;
        repeat (10) @(negedge clk);
        start0 = 1'b1; @(negedge clk); start0 = 1'b0;
        repeat (40) @(negedge clk);
        chk(d0_n == 1 && d0_c == t0 + 64, "R6 latency kept", d0_c - t0, 64);
        chk(d0_r == ea, "R6 value kept", d0_r, ea);
        chk(err0 == 0, "R6 step order kept", err0, 0);

        // R7: result holds through the next run
        fill_rand(32'h5A5A);
        eb = model_sum();
        pulse_both();
        repeat (30) @(negedge clk);
        chk(longint'(result0) == ea, "R7 result held mid-run", result0, ea);
        repeat (40) @(negedge clk);
        chk(d0_r == eb && longint'(result0) == eb, "R7 result updated", result0, eb);
        chk(d1_r == eb, "R4 dedicated after hold", d1_r, eb);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule